// File: doc/BRIEF.md
# Quadrature Square Reference Generator

This block derives three square reference bits from the system clock for a lock-in demodulator. The bits are a reference, a copy shifted by about a quarter period, and a copy shifted by a programmable number of clock ticks. Each bit is also presented as a 14-bit signed level: a high bit gives +4096 and a low bit gives -4096. These levels feed the mixers and the output stage directly.

A non-zero period setting runs the block as a divider. A single counter wraps every 2·(setting+1) clocks, and each bit is high for the first setting+1 ticks of its own shifted copy of that count. A period setting of zero switches the block to follow mode. In follow mode the reference bit tracks the polarity of a supplied cosine sample and the quadrature bit tracks the polarity of a supplied sine sample, so the square and harmonic oscillators stay locked together. The shifted bit then comes from a bounded delay line on the reference polarity. Writing a new period or phase setting restarts the counter, so all three bits start again from a common edge.

Top module: `sqref_quad_gen`

## Requirements
- R1: With period setting S > 0, the reference bit is high for S+1 clocks and then low for S+1 clocks. The pattern repeats every 2·(S+1) clocks, and the count starts at the beginning of the high half.
- R2: With S = 0, the reference bit registers the polarity of the cosine sample and the quadrature bit registers the polarity of the sine sample, one clock after the sample. A sample ≥ 0 gives 1 and a negative sample (sign bit 1) gives 0.
- R3: With S > 0, the quadrature bit is the reference pattern delayed by (S>>1)+1 clocks, with the shift truncating.
- R4: With S > 0, the phase bit is the reference pattern delayed by P mod 2·(S+1) clocks, where P is the phase setting.
- R5: With S = 0, the phase bit is the reference bit delayed by min(P, 255) clocks.
- R6: Each level output is +4096 when its bit is 1 and -4096 when its bit is 0, as a 14-bit two's-complement value.
- R7: Any change of S or P restarts the count. The second clock edge after the change produces count position 0 of the new setting.
- R8: A synchronous active-low reset clears all three bits, so all levels read -4096.
- R9: S = 1 gives the fastest divider pattern, with a period of four clocks (1100 on the reference bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sqp | input | 16 | Half-period setting; 0 selects follow mode |
| phase_sq | input | 16 | Phase delay in clock ticks |
| cos_in | input | 14 | Signed cosine sample from the harmonic oscillator |
| sin_in | input | 14 | Signed sine sample from the harmonic oscillator |
| ref_bit | output | 1 | Reference square bit |
| quad_bit | output | 1 | Quadrature square bit |
| phase_bit | output | 1 | Phase-shifted square bit |
| ref_level | output | 14 | Signed level of the reference bit |
| quad_level | output | 14 | Signed level of the quadrature bit |
| phase_level | output | 14 | Signed level of the phase bit |

## Verification
In divider mode a setting change is taken on the next edge. The outputs after the k-th edge that follows it (k ≥ 1) therefore show count position k-1. The bench counts edges from the change, skips the single transitional edge, and sweeps many period and phase pairs, including phases beyond one period. In follow mode a sample driven before an edge appears on the reference and quadrature bits right after that edge. The phase bit shows the same sample min(P,255) edges later, so the bench keeps a history of driven polarities and checks the phase bit against the entry that many edges back. All samples are taken at the falling clock edge.

// File: rtl/sqref_pkg.sv
// Package: shared tap indices and helpers for the square reference generator.
// Assumes three taps in a fixed order: reference, quadrature, phase.
package sqref_pkg;

    localparam int TAP_REF   = 0;
    localparam int TAP_QUAD  = 1;
    localparam int TAP_PHASE = 2;
    localparam int TAP_COUNT = 3;

    // Source of the square bits.
    typedef enum logic {
        SRC_DIVIDER = 1'b0,
        SRC_FOLLOW  = 1'b1
    } sq_src_e;

    // Clamp a delay request to the delay line depth.
    function automatic int unsigned clamp_delay(input int unsigned req, input int unsigned max_d);
        return (req > max_d) ? max_d : req;
    endfunction

endpackage

// File: rtl/sqref_timebase.sv
// Timebase: registers the period and phase settings and runs the wrapping tick
// counter. The counter restarts on any setting change.
// Assumes: settings are sampled every clock; the period is never zero (>= 2).
module sqref_timebase #(
    parameter int SQP_W = 16,
    parameter int PH_W  = 16,
    localparam int CNT_W = SQP_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SQP_W-1:0] sqp_in,
    input  logic [PH_W-1:0]  ph_in,
    output logic [SQP_W-1:0] sqp_q,
    output logic [PH_W-1:0]  ph_q,
    output logic             restart,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] half
);

    // Detect a setting change against the held copy.
    assign restart = (sqp_in != sqp_q) || (ph_in != ph_q);

    // Half period is setting+1 ticks; full period is twice that.
    assign half   = CNT_W'(sqp_q) + CNT_W'(1);
    assign period = half << 1;

    // Hold settings and advance or restart the tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sqp_q <= '0;
            ph_q  <= '0;
            cnt   <= '0;
        end else if (restart) begin
            sqp_q <= sqp_in;
            ph_q  <= ph_in;
            cnt   <= '0;
        end else if (cnt == period - CNT_W'(1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < period);

    p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && cnt == period - CNT_W'(1)) |=> (cnt == '0));

endmodule

// File: rtl/sqref_phase_cmp.sv
// Phase comparator: yields a square bit that is the reference pattern delayed
// by 'lag' ticks, by comparing the shifted count position with the half period.
// Assumes: cnt < period and lag < period.
module sqref_phase_cmp #(
    parameter int CNT_W = 18
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] half,
    input  logic [CNT_W-1:0] lag,
    output logic             bit_o
);

    logic [CNT_W-1:0] pos;

    // Shift the count back by the lag modulo the period, then test the high half.
    always_comb begin
        if (cnt >= lag) pos = cnt - lag;
        else            pos = cnt + period - lag;
        bit_o = (pos < half);
    end

endmodule

// File: rtl/sqref_sign_delay.sv
// Follow-mode delay line: a shift register of past polarity bits with a tap
// chosen by the phase setting, clamped to the line depth. Tap 0 passes the
// input straight through.
// Assumes: caller registers the tap output.
module sqref_sign_delay #(
    parameter int DLY_MAX = 255,
    parameter int PH_W    = 16,
    localparam int DW     = $clog2(DLY_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_in,
    input  logic [PH_W-1:0] ph,
    output logic            tap_o
);

    logic [DLY_MAX-1:0] line_q;
    logic [DW-1:0]      dly;

    // Clamp the requested delay to the line depth.
    assign dly = (ph > PH_W'(DLY_MAX)) ? DW'(DLY_MAX) : DW'(ph);

    // Shift the polarity history one place each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= {line_q[DLY_MAX-2:0], bit_in};
    end

    // Pick the requested history entry.
    always_comb begin
        if (dly == '0) tap_o = bit_in;
        else           tap_o = line_q[dly - DW'(1)];
    end

endmodule

// File: rtl/sqref_level_map.sv
// Level map: converts one square bit to a signed symmetric level.
// Assumes LEVEL_MAG fits in DATA_W-1 magnitude bits.
module sqref_level_map #(
    parameter int DATA_W    = 14,
    parameter int LEVEL_MAG = 4096
) (
    input  logic                     bit_i,
    output logic signed [DATA_W-1:0] level_o
);

    localparam logic signed [DATA_W-1:0] POS = DATA_W'(LEVEL_MAG);
    localparam logic signed [DATA_W-1:0] NEG = -POS;

    // Select the positive or negative level.
    assign level_o = bit_i ? POS : NEG;

endmodule

// File: rtl/sqref_quad_gen.sv
// Square reference generator top: divider mode (sqp > 0) builds three shifted
// square bits from one counter; follow mode (sqp == 0) takes the polarities of
// the harmonic samples and delays the cosine polarity for the phase bit.
// Assumes: PH_W <= SQP_W + 2; bits are registered once before the outputs.
module sqref_quad_gen
    import sqref_pkg::*;
#(
    parameter int SQP_W     = 16,
    parameter int PH_W      = 16,
    parameter int DATA_W    = 14,
    parameter int LEVEL_MAG = 4096,
    parameter int DLY_MAX   = 255
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SQP_W-1:0]         sqp,
    input  logic [PH_W-1:0]          phase_sq,
    input  logic signed [DATA_W-1:0] cos_in,
    input  logic signed [DATA_W-1:0] sin_in,
    output logic                     ref_bit,
    output logic                     quad_bit,
    output logic                     phase_bit,
    output logic signed [DATA_W-1:0] ref_level,
    output logic signed [DATA_W-1:0] quad_level,
    output logic signed [DATA_W-1:0] phase_level
);

    localparam int CNT_W = SQP_W + 2;

    logic [SQP_W-1:0] sqp_q;
    logic [PH_W-1:0]  ph_q;
    logic             restart;
    logic [CNT_W-1:0] cnt, period, half;
    sq_src_e          src;

    sqref_timebase #(.SQP_W(SQP_W), .PH_W(PH_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .sqp_in  (sqp),
        .ph_in   (phase_sq),
        .sqp_q   (sqp_q),
        .ph_q    (ph_q),
        .restart (restart),
        .cnt     (cnt),
        .period  (period),
        .half    (half)
    );

    // A zero period setting selects follow mode.
    assign src = (sqp_q == '0) ? SRC_FOLLOW : SRC_DIVIDER;

    // Per-tap lag in divider mode.
    logic [CNT_W-1:0] lag [TAP_COUNT];
    always_comb begin
        lag[TAP_REF]   = '0;
        lag[TAP_QUAD]  = CNT_W'(sqp_q >> 1) + CNT_W'(1);
        lag[TAP_PHASE] = CNT_W'(ph_q) % period;
    end

    logic [TAP_COUNT-1:0] div_bit;
    for (genvar g = 0; g < TAP_COUNT; g++) begin : g_cmp
        sqref_phase_cmp #(.CNT_W(CNT_W)) u_cmp (
            .cnt    (cnt),
            .period (period),
            .half   (half),
            .lag    (lag[g]),
            .bit_o  (div_bit[g])
        );
    end

    // Polarity of the harmonic samples: non-negative gives 1.
    logic cos_pos, sin_pos, dly_tap;
    assign cos_pos = (cos_in >= $signed(DATA_W'(0)));
    assign sin_pos = (sin_in >= $signed(DATA_W'(0)));

    sqref_sign_delay #(.DLY_MAX(DLY_MAX), .PH_W(PH_W)) u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_in (cos_pos),
        .ph     (ph_q),
        .tap_o  (dly_tap)
    );

    // Register the three bits from the selected source.
    logic [TAP_COUNT-1:0] bit_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                  bit_q <= '0;
        else if (src == SRC_FOLLOW)  bit_q <= {dly_tap, sin_pos, cos_pos};
        else                         bit_q <= div_bit;
    end

    assign ref_bit   = bit_q[TAP_REF];
    assign quad_bit  = bit_q[TAP_QUAD];
    assign phase_bit = bit_q[TAP_PHASE];

    logic signed [DATA_W-1:0] lvl [TAP_COUNT];
    for (genvar g = 0; g < TAP_COUNT; g++) begin : g_lvl
        sqref_level_map #(.DATA_W(DATA_W), .LEVEL_MAG(LEVEL_MAG)) u_map (
            .bit_i   (bit_q[g]),
            .level_o (lvl[g])
        );
    end

    assign ref_level   = lvl[TAP_REF];
    assign quad_level  = lvl[TAP_QUAD];
    assign phase_level = lvl[TAP_PHASE];

    p_follow_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && src == SRC_FOLLOW) |=> (ref_bit == $past(cos_pos)));

    p_follow_quad_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && src == SRC_FOLLOW) |=> (quad_bit == $past(sin_pos)));

    p_follow_zero_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && src == SRC_FOLLOW && ph_q == '0) |=> (phase_bit == $past(cos_pos)));

    p_ref_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && src == SRC_DIVIDER && cnt == '0) |=> ref_bit);

    p_ref_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && src == SRC_DIVIDER && cnt == half) |=> !ref_bit);

    p_quad_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && src == SRC_DIVIDER && cnt == lag[TAP_QUAD]) |=> quad_bit);

endmodule

// File: tb/sqref_quad_gen_tb_top.sv
module sqref_quad_gen_tb_top;

    localparam int DATA_W = 14;
    localparam int MAG    = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] sqp = 16'd3;
    logic [15:0] phase_sq = 16'd0;
    logic signed [DATA_W-1:0] cos_in = '0;
    logic signed [DATA_W-1:0] sin_in = '0;
    logic ref_bit, quad_bit, phase_bit;
    logic signed [DATA_W-1:0] ref_level, quad_level, phase_level;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sqref_quad_gen dut_i (
        .clk(clk), .rst_n(rst_n), .sqp(sqp), .phase_sq(phase_sq),
        .cos_in(cos_in), .sin_in(sin_in),
        .ref_bit(ref_bit), .quad_bit(quad_bit), .phase_bit(phase_bit),
        .ref_level(ref_level), .quad_level(quad_level), .phase_level(phase_level)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int lvl_of(input bit b);
        return b ? MAG : -MAG;
    endfunction

    // R6: levels checked against the expected bits
    task automatic chk_levels(input bit er, input bit eq, input bit ep);
        chk("R6", "ref_level",   int'(ref_level),   lvl_of(er));
        chk("R6", "quad_level",  int'(quad_level),  lvl_of(eq));
        chk("R6", "phase_level", int'(phase_level), lvl_of(ep));
    endtask

    function automatic bit pat(input int m, input int lag, input int p, input int h);
        int pos;
        pos = ((m - lag) % p + p) % p;
        return pos < h;
    endfunction

    // Divider mode sweep: R1, R3, R4, R7, R9
    task automatic run_div(input int s, input int ph, input int cycles);
        int p, h, q, pm;
        p = 2 * (s + 1); h = s + 1; q = (s >> 1) + 1; pm = ph % p;
        @(negedge clk);
        sqp = 16'(s); phase_sq = 16'(ph);
        @(posedge clk);
        for (int k = 1; k <= cycles; k++) begin
            int m;
            bit er, eq, ep;
            @(posedge clk);
            @(negedge clk);
            m = (k - 1) % p;
            er = pat(m, 0, p, h); eq = pat(m, q, p, h); ep = pat(m, pm, p, h);
            if (k == 1) chk("R7", "ref_bit after restart", int'(ref_bit), 1);
            if (s == 1) chk("R9", "ref_bit fastest", int'(ref_bit), int'(er));
            else        chk("R1", "ref_bit", int'(ref_bit), int'(er));
            chk("R3", "quad_bit", int'(quad_bit), int'(eq));
            chk("R4", "phase_bit", int'(phase_bit), int'(ep));
            chk_levels(er, eq, ep);
        end
    endtask

    // Follow mode: R2, R5
    task automatic run_follow(input int ph, input int cycles);
        bit hc [0:1023];
        bit hs [0:1023];
        int dd;
        dd = (ph > 255) ? 255 : ph;
        @(negedge clk);
        sqp = 16'd0; phase_sq = 16'(ph); cos_in = 14'sd100; sin_in = 14'sd100;
        @(posedge clk);
        @(posedge clk);
        for (int t = 0; t <= cycles; t++) begin
            @(negedge clk);
            if (t > 0) begin
                chk("R2", "ref_bit follows cosine", int'(ref_bit), int'(hc[t-1]));
                chk("R2", "quad_bit follows sine", int'(quad_bit), int'(hs[t-1]));
                if (t - 1 - dd >= 0)
                    chk("R5", "phase_bit delayed", int'(phase_bit), int'(hc[t-1-dd]));
                chk("R6", "ref_level", int'(ref_level), lvl_of(hc[t-1]));
            end
            if (t < cycles) begin
                bit cb, sb;
                cb = ((t * 5 + ph) % 7) < 3;
                sb = ((t * 3 + 1) % 4) < 2;
                hc[t] = cb; hs[t] = sb;
                cos_in = cb ? ((t % 2) ? 14'sd0 : 14'sd8191) : ((t % 2) ? -14'sd1 : -14'sd8192);
                sin_in = sb ? 14'sd2000 : -14'sd2000;
            end
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R8: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8", "ref_bit in reset", int'(ref_bit), 0);
        chk("R8", "quad_bit in reset", int'(quad_bit), 0);
        chk("R8", "phase_bit in reset", int'(phase_bit), 0);
        chk("R8", "ref_level in reset", int'(ref_level), -MAG);
        rst_n = 1'b1;

        for (int s = 1; s <= 9; s++) begin
            run_div(s, 0, 3 * 2 * (s + 1));
            run_div(s, 1, 2 * 2 * (s + 1));
            run_div(s, s + 2, 2 * 2 * (s + 1));
            run_div(s, 2 * 2 * (s + 1) + 3, 2 * 2 * (s + 1));
            run_div(s, 40000 + s, 2 * 2 * (s + 1));
        end
        run_div(200, 77, 900);
        // R7: change phase only in the middle of a period
        run_div(5, 0, 7);
        run_div(5, 3, 30);
        run_div(6, 3, 30);

        run_follow(0, 40);
        run_follow(1, 40);
        run_follow(5, 60);
        run_follow(300, 600);

        // back to divider from follow mode
        run_div(3, 2, 24);

        // R8: synchronous reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R8", "ref_bit after reset", int'(ref_bit), 0);
        chk("R8", "quad_bit after reset", int'(quad_bit), 0);
        chk("R8", "phase_level after reset", int'(phase_level), -MAG);
        rst_n = 1'b1;

        done = 1'b1;
        finish_run();
    end

endmodule